// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in word-addressed memory and turns each one into either a byte stream for the transmitter or a short burst of words for an address filter. A descriptor is four 32-bit words at a 16-byte stride: word 0 holds status, word 1 holds the control flags and byte count, word 2 holds the buffer address, and word 3 is unused. Software fills a descriptor, hands it to the engine by setting bit 31 of word 0, and then writes the value 1 to the poll port. Once the engine has finished with a descriptor it writes a completion status back to word 0 with bit 31 clear. Software polls that bit to learn that the buffer can be reused.

The engine only runs while `tx_run` is high. While it is stopped and idle, its descriptor pointer is held at `ring_base`. After a poll, it keeps fetching descriptors until it reads one whose bit 31 is clear, then suspends in IDLE until the next poll. A descriptor marked end-of-ring sends the next fetch back to `ring_base`. The memory port has a fixed latency: read data appears on `mem_rdata` in the cycle after the request.

The controller is one state machine with these states. IDLE waits for a poll. RSTAT issues the status read. RCTRL checks ownership and issues the control read. RBUFA captures the flags and issues the buffer-address read. DECIDE classifies the descriptor. BREAD and BLOAD read one buffer word and capture it, and EMIT sends its bytes out. SREAD and SPUSH read and forward setup words. WBACK writes the status back and advances the pointer.

The transitions are:
- IDLE goes to RSTAT on a pending poll while running.
- RCTRL goes back to IDLE if the descriptor is not owned, otherwise to RBUFA.
- DECIDE goes to WBACK on an error, to SREAD for a setup frame, and to BREAD otherwise.
- EMIT goes to BREAD after the fourth byte of a word, and to WBACK after the last byte.
- SPUSH goes to SREAD while words remain, otherwise to WBACK.
- WBACK goes to RSTAT while running, otherwise to IDLE.

Top module: `txd_engine`

## Requirements
- R1: After reset, `mem_req`, `out_valid`, `setup_valid` and `tx_err` are all low, and the engine is in IDLE with its pointer at `ring_base`.
- R2: A write on `poll_wr` whose `poll_data` equals 1, made while `tx_run` is high, starts a fetch of word 0 at the current pointer. A poll with any other data value causes no memory access.
- R3: If a fetched word 0 has bit 31 clear, the engine makes no further access, streams nothing and writes nothing back. It waits for the next poll.
- R4: For an owned descriptor with bit 29 (first) and bit 30 (last) both set in word 1 and a nonzero length, the engine streams exactly that many bytes in address order. Byte k of each buffer word comes from bits [8k+7:8k]. `out_last` is set on the final byte only, and 0x00000000 is written back to word 0.
- R5: Every write to memory targets word 0 of the current descriptor and has bit 31 clear.
- R6: A zero length, or a non-setup descriptor that is missing bit 29 or bit 30, streams no bytes. It writes back 0x00008000 (bit 15 set, bit 31 clear) and pulses `tx_err` for one cycle.
- R7: A descriptor with bit 27 set in word 1 and a nonzero length streams no bytes. It presents ceil(length/4) buffer words on `setup_data`, with `setup_index` counting up from 0, and writes back 0x7FFFFFFF.
- R8: After a descriptor with bit 25 set in word 1, the next fetch is at `ring_base`; otherwise it is 16 bytes further on. Processing continues until an unowned descriptor is found.
- R9: While `tx_run` is low, polls are ignored. A descriptor already in progress completes, but no further descriptor is fetched. The next start fetches from `ring_base`.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R11: The byte length is taken from bits [10:0] of word 1 only. Other bits of word 1 outside 25, 27, 29 and 30 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_run | input | 1 | Start/stop control for transmission |
| ring_base | input | 32 | Byte address of descriptor 0 |
| poll_wr | input | 1 | Poll register write strobe |
| poll_data | input | 32 | Value written to the poll register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame |
| setup_valid | output | 1 | Setup word valid |
| setup_index | output | 9 | Word index within the setup frame |
| setup_data | output | 32 | Setup frame word |
| tx_err | output | 1 | One-cycle pulse on a rejected descriptor |

## Verification
A directed ring of three good frames, with the last one marked end-of-ring, checks byte order, the last-byte marking and the wrap back to the base. One of the three has stray bits set in word 1, which shows that only bits [10:0] set the length. A second ring mixes a zero-length descriptor, one with only the first flag, one with only the last flag, and a setup frame. This separates the two error causes from the setup diversion by their written-back status, `tx_err` pulses and setup words.

Random rounds draw lengths and descriptor kinds while a random `out_ready` stalls the stream. Polls made while stopped, polls with the wrong value, a poll with nothing owned, and a stop issued in the middle of a frame each show whether a stray fetch, a lost fetch or a missed rewind to the base occurs.

// File: rtl/txd_pkg.sv
package txd_pkg;

    // Descriptor layout
    localparam int DESC_BYTES = 16;
    localparam int WORD_BYTES = 4;

    // Word 0 / word 1 bit positions
    localparam int OWN_BIT   = 31;
    localparam int LAST_BIT  = 30;
    localparam int FIRST_BIT = 29;
    localparam int SETUP_BIT = 27;
    localparam int WRAP_BIT  = 25;

    // Completion codes written back to word 0
    localparam logic [31:0] STAT_DONE  = 32'h0000_0000;
    localparam logic [31:0] STAT_FAIL  = 32'h0000_8000;
    localparam logic [31:0] STAT_SETUP = 32'h7FFF_FFFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RSTAT,
        S_RCTRL,
        S_RBUFA,
        S_DECIDE,
        S_BREAD,
        S_BLOAD,
        S_EMIT,
        S_SREAD,
        S_SPUSH,
        S_WBACK
    } txd_state_e;

endpackage

// File: rtl/txd_poll_gate.sv
module txd_poll_gate #(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] POLL_VAL = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              consume,
    output logic              go
);
    logic pend_q;
    logic hit;

    assign hit = wr && run && (wdata == DATA_W'(POLL_VAL));
    assign go  = pend_q || hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!run || consume) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic              load_base,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] cur
);
    logic [ADDR_W-1:0] cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load_base) begin
            cur_q <= base;
        end else if (advance) begin
            cur_q <= wrap ? base : cur_q + ADDR_W'(DESC_BYTES);
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/txd_byte_sel.sv
module txd_byte_sel #(
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*8-1:0] word,
    input  logic [LANE_W-1:0]  lane,
    output logic [7:0]         byte_o
);
    logic [7:0] lane_b [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = word[g*8 +: 8];
    end

    assign byte_o = lane_b[lane];
endmodule

// File: rtl/txd_engine.sv
module txd_engine
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11,
    parameter int IDX_W  = LEN_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_run,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              poll_wr,
    input  logic [DATA_W-1:0] poll_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              setup_valid,
    output logic [IDX_W-1:0]  setup_index,
    output logic [DATA_W-1:0] setup_data,
    output logic              tx_err
);
    localparam int LANES    = DATA_W / 8;
    localparam int LANE_W   = $clog2(LANES);
    localparam logic [LANE_W-1:0] LANE_END = LANE_W'(LANES - 1);
    localparam logic [ADDR_W-1:0] W1_OFS   = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] W2_OFS   = ADDR_W'(2 * WORD_BYTES);
    localparam logic [LEN_W-1:0]  WORD_LEN = LEN_W'(WORD_BYTES);

    txd_state_e state_q, state_d;

    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] wb_q;
    logic [LANE_W-1:0] lane_q;
    logic [LEN_W-1:0]  left_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  sidx_q;
    logic              last_q, first_q, setup_q, wrap_q, err_q;

    logic poll_go, consume, load_base, advance;
    logic fire, bad_desc;
    logic [7:0] lane_byte;

    txd_poll_gate #(.DATA_W(DATA_W)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tx_run),
        .wr      (poll_wr),
        .wdata   (poll_data),
        .consume (consume),
        .go      (poll_go)
    );

    txd_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (ring_base),
        .load_base (load_base),
        .advance   (advance),
        .wrap      (wrap_q),
        .cur       (cur)
    );

    txd_byte_sel #(.LANES(LANES)) u_sel (
        .word   (word_q),
        .lane   (lane_q),
        .byte_o (lane_byte)
    );

    assign fire     = (state_q == S_EMIT) && out_ready;
    assign bad_desc = (len_q == '0) || (!setup_q && !(first_q && last_q));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (tx_run && poll_go) state_d = S_RSTAT;
            S_RSTAT:  state_d = S_RCTRL;
            S_RCTRL:  state_d = mem_rdata[OWN_BIT] ? S_RBUFA : S_IDLE;
            S_RBUFA:  state_d = S_DECIDE;
            S_DECIDE: begin
                if (bad_desc)     state_d = S_WBACK;
                else if (setup_q) state_d = S_SREAD;
                else              state_d = S_BREAD;
            end
            S_BREAD:  state_d = S_BLOAD;
            S_BLOAD:  state_d = S_EMIT;
            S_EMIT: begin
                if (fire && left_q == LEN_W'(1)) state_d = S_WBACK;
                else if (fire && lane_q == LANE_END) state_d = S_BREAD;
            end
            S_SREAD:  state_d = S_SPUSH;
            S_SPUSH:  state_d = (left_q <= WORD_LEN) ? S_WBACK : S_SREAD;
            S_WBACK:  state_d = tx_run ? S_RSTAT : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = cur;
        mem_wdata   = wb_q;
        out_valid   = 1'b0;
        out_data    = lane_byte;
        out_last    = 1'b0;
        setup_valid = 1'b0;
        setup_index = sidx_q;
        setup_data  = mem_rdata;
        tx_err      = 1'b0;
        consume     = 1'b0;
        load_base   = 1'b0;
        advance     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                load_base = !tx_run;
                consume   = tx_run && poll_go;
            end
            S_RSTAT: mem_req = 1'b1;
            S_RCTRL: begin
                mem_req  = mem_rdata[OWN_BIT];
                mem_addr = cur + W1_OFS;
            end
            S_RBUFA: begin
                mem_req  = 1'b1;
                mem_addr = cur + W2_OFS;
            end
            S_DECIDE: ;
            S_BREAD, S_SREAD: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q;
            end
            S_BLOAD: ;
            S_EMIT: begin
                out_valid = 1'b1;
                out_last  = (left_q == LEN_W'(1));
            end
            S_SPUSH: setup_valid = 1'b1;
            S_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                tx_err  = err_q;
                advance = 1'b1;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            word_q  <= '0;
            wb_q    <= '0;
            lane_q  <= '0;
            left_q  <= '0;
            len_q   <= '0;
            sidx_q  <= '0;
            last_q  <= 1'b0;
            first_q <= 1'b0;
            setup_q <= 1'b0;
            wrap_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_RBUFA: begin
                    len_q   <= mem_rdata[LEN_W-1:0];
                    last_q  <= mem_rdata[LAST_BIT];
                    first_q <= mem_rdata[FIRST_BIT];
                    setup_q <= mem_rdata[SETUP_BIT];
                    wrap_q  <= mem_rdata[WRAP_BIT];
                end
                S_DECIDE: begin
                    ptr_q  <= {mem_rdata[ADDR_W-1:2], 2'b00};
                    left_q <= len_q;
                    sidx_q <= '0;
                    err_q  <= bad_desc;
                    if (bad_desc)     wb_q <= STAT_FAIL;
                    else if (setup_q) wb_q <= STAT_SETUP;
                    else              wb_q <= STAT_DONE;
                end
                S_BLOAD: begin
                    word_q <= mem_rdata;
                    lane_q <= '0;
                end
                S_EMIT: begin
                    if (fire) begin
                        left_q <= left_q - LEN_W'(1);
                        lane_q <= lane_q + LANE_W'(1);
                        if (lane_q == LANE_END) ptr_q <= ptr_q + W1_OFS;
                    end
                end
                S_SPUSH: begin
                    ptr_q  <= ptr_q + W1_OFS;
                    sidx_q <= sidx_q + IDX_W'(1);
                    left_q <= (left_q > WORD_LEN) ? left_q - WORD_LEN : '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_last,
    input logic              setup_valid,
    input logic              tx_err
);
    a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r5_own_released: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    a_r6_err_status: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> mem_req && mem_we && mem_wdata == 32'h0000_8000);

    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> !tx_err);

    a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r7_single_sink: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && setup_valid));

    a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind txd_engine txd_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last),
    .setup_valid (setup_valid),
    .tx_err      (tx_err)
);

// File: tb/txd_engine_tb_top.sv
module txd_engine_tb_top;
    localparam logic [31:0] BASE = 32'h100;
    localparam int BASE_W = 64;
    localparam int BUF_W  = 128;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_run;
    logic [31:0] ring_base;
    logic poll_wr;
    logic [31:0] poll_data;
    logic mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic out_valid, out_ready, out_last;
    logic [7:0] out_data;
    logic setup_valid;
    logic [8:0] setup_index;
    logic [31:0] setup_data;
    logic tx_err;

    always #2 clk = ~clk;

    txd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .tx_run(tx_run), .ring_base(ring_base),
        .poll_wr(poll_wr), .poll_data(poll_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .setup_valid(setup_valid),
        .setup_index(setup_index), .setup_data(setup_data), .tx_err(tx_err)
    );

    // Memory model: one-cycle read latency, plus a bench write port
    logic [31:0] mem [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_idx = '0;
    logic [31:0] tb_wd = '0;

    always @(posedge clk) begin
        if (tb_we) mem[tb_idx] <= tb_wd;
        if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    end

    always @(negedge clk) out_ready <= ($urandom % 4) != 0;

    // Monitor
    logic [7:0]  byte_q [$];
    logic [31:0] sword_q [$];
    logic [8:0]  sidx_q [$];
    int rd_cnt = 0, wr_cnt = 0, err_cnt = 0, last_cnt = 0, quiet = 0, cyc = 0;
    logic [31:0] last_rd = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req || out_valid || setup_valid) quiet <= 0;
        else quiet <= quiet + 1;
        if (mem_req && !mem_we) begin
            rd_cnt <= rd_cnt + 1;
            last_rd <= mem_addr;
        end
        if (mem_req && mem_we) wr_cnt <= wr_cnt + 1;
        if (out_valid && out_ready) begin
            byte_q.push_back(out_data);
            if (out_last) last_cnt <= last_cnt + 1;
        end
        if (setup_valid) begin
            sword_q.push_back(setup_data);
            sidx_q.push_back(setup_index);
        end
        if (tx_err) err_cnt <= err_cnt + 1;
    end

    int n_tests = 0, n_fail = 0;

    always @(posedge clk) begin
        if (cyc == 150000) begin
            $display("FAIL R1 watchdog: cycles=%0d expected < %0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_idx = idx[7:0]; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic poll(input logic [31:0] v);
        @(negedge clk);
        poll_wr = 1'b1; poll_data = v;
        @(negedge clk);
        poll_wr = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic wait_quiet();
        while (quiet < 40) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected results, built from the requirements
    logic [7:0]  exp_bytes [$];
    logic [31:0] exp_words [$];
    logic [8:0]  exp_idx [$];
    logic [31:0] exp_stat [4];
    int exp_err, exp_last;

    function automatic logic [31:0] stat_for(input int len, input int kind);
        bit bad = (len == 0) || (kind == 2) || (kind == 3);
        if (bad) return 32'h0000_8000;     // R6
        if (kind == 1) return 32'h7FFF_FFFF; // R7
        return 32'h0;                        // R4
    endfunction

    // kind: 0 normal, 1 setup, 2 first only, 3 last only, 4 normal + stray bits
    task automatic build(input int k, input int len, input int kind, input bit eor, input bit own);
        logic [31:0] ctrl, d, st;
        int nw;
        ctrl = 32'(len);
        case (kind)
            0: ctrl |= 32'h6000_0000;
            1: ctrl |= 32'h0800_0000;
            2: ctrl |= 32'h2000_0000;
            3: ctrl |= 32'h4000_0000;
            default: ctrl |= 32'h6010_4800; // R11 stray bits 20, 14, 11
        endcase
        if (eor) ctrl |= 32'h0200_0000;
        st = stat_for(len, kind);
        exp_stat[k] = st;
        nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            d = $urandom;
            wr(BUF_W + k * 16 + w, d);
            if (st == 32'h0) begin
                for (int b = 0; b < 4; b++)
                    if (w * 4 + b < len) exp_bytes.push_back(d[b*8 +: 8]);
            end else if (st == 32'h7FFF_FFFF) begin
                exp_words.push_back(d);
                exp_idx.push_back(9'(w));
            end
        end
        if (st == 32'h0000_8000) exp_err++;
        if (st == 32'h0) exp_last++;
        wr(BASE_W + 4 * k,     own ? 32'h8000_0000 : 32'h0);
        wr(BASE_W + 4 * k + 1, ctrl);
        wr(BASE_W + 4 * k + 2, 32'h200 + 32'(k * 64));
        wr(BASE_W + 4 * k + 3, 32'hDEAD_0000);
    endtask

    task automatic clear_exp();
        exp_bytes.delete(); exp_words.delete(); exp_idx.delete();
        exp_err = 0; exp_last = 0;
    endtask

    task automatic run_ring(input int nd, input string tag);
        int b0 = byte_q.size(), s0 = sword_q.size(), e0 = err_cnt, l0 = last_cnt;
        int mism = 0;
        poll(32'd1);
        wait_quiet();
        chk(byte_q.size() - b0 == exp_bytes.size(), "R4", {tag, " byte count"},
            32'(byte_q.size() - b0), 32'(exp_bytes.size()));
        for (int i = 0; i < exp_bytes.size() && b0 + i < byte_q.size(); i++)
            if (byte_q[b0 + i] !== exp_bytes[i]) mism++;
        chk(mism == 0, "R4", {tag, " byte mismatches"}, 32'(mism), 32'd0);
        chk(last_cnt - l0 == exp_last, "R4", {tag, " last markers"},
            32'(last_cnt - l0), 32'(exp_last));
        chk(err_cnt - e0 == exp_err, "R6", {tag, " error pulses"},
            32'(err_cnt - e0), 32'(exp_err));
        chk(sword_q.size() - s0 == exp_words.size(), "R7", {tag, " setup words"},
            32'(sword_q.size() - s0), 32'(exp_words.size()));
        mism = 0;
        for (int i = 0; i < exp_words.size() && s0 + i < sword_q.size(); i++)
            if (sword_q[s0 + i] !== exp_words[i] || sidx_q[s0 + i] !== exp_idx[i]) mism++;
        chk(mism == 0, "R7", {tag, " setup data/index"}, 32'(mism), 32'd0);
        for (int k = 0; k < nd; k++)
            chk(mem[BASE_W + 4 * k] === exp_stat[k], "R5", {tag, " written status"},
                mem[BASE_W + 4 * k], exp_stat[k]);
        chk(last_rd === BASE, "R8", {tag, " wrap to base"}, last_rd, BASE);
    endtask

    initial begin
        int r0, w0, b0;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; tx_run = 1'b0; ring_base = BASE; poll_wr = 1'b0; poll_data = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!mem_req && !out_valid && !setup_valid && !tx_err, "R1", "outputs in reset",
            {28'd0, mem_req, out_valid, setup_valid, tx_err}, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) wr(BASE_W + 4 * k, 32'h0);

        // R9: poll while stopped is ignored
        r0 = rd_cnt;
        poll(32'd1);
        wait_quiet();
        chk(rd_cnt == r0, "R9", "reads after poll while stopped", 32'(rd_cnt - r0), 32'd0);

        // R2: wrong poll value is ignored
        tx_run = 1'b1;
        r0 = rd_cnt;
        poll(32'd2);
        wait_quiet();
        chk(rd_cnt == r0, "R2", "reads after poll value 2", 32'(rd_cnt - r0), 32'd0);

        // R2/R4/R8/R11: directed ring of three good frames
        clear_exp();
        build(0, 5, 0, 1'b0, 1'b1);
        build(1, 13, 4, 1'b0, 1'b1);
        build(2, 8, 0, 1'b1, 1'b1);
        run_ring(3, "R11 directed");

        // R3: nothing owned, one status read and no write
        r0 = rd_cnt; w0 = wr_cnt; b0 = byte_q.size();
        poll(32'd1);
        wait_quiet();
        chk(rd_cnt - r0 == 1, "R3", "reads with no owned descriptor", 32'(rd_cnt - r0), 32'd1);
        chk(wr_cnt == w0 && byte_q.size() == b0, "R3", "writes/bytes when unowned",
            32'(wr_cnt - w0), 32'd0);
        chk(last_rd === BASE, "R2", "fetch at current pointer", last_rd, BASE);

        // R6/R7: error kinds and a setup frame
        clear_exp();
        build(0, 0, 0, 1'b0, 1'b1);
        build(1, 9, 2, 1'b0, 1'b1);
        build(2, 7, 3, 1'b0, 1'b1);
        build(3, 10, 1, 1'b1, 1'b1);
        run_ring(4, "R6 errors and setup");

        // Random rounds under random backpressure (R10 via stalls)
        for (int rnd = 0; rnd < 8; rnd++) begin
            clear_exp();
            for (int k = 0; k < 4; k++) begin
                int kind = $urandom % 6;
                if (kind > 4) kind = 0;
                build(k, $urandom % 25, kind, k == 3, 1'b1);
            end
            run_ring(4, "R10 random");
        end

        // R9: stop during a frame
        clear_exp();
        build(0, 20, 0, 1'b0, 1'b1);
        build(1, 8, 0, 1'b1, 1'b1);
        b0 = byte_q.size();
        poll(32'd1);
        while (!out_valid) @(posedge clk);
        @(negedge clk);
        tx_run = 1'b0;
        wait_quiet();
        chk(byte_q.size() - b0 == 20, "R9", "bytes of frame in progress",
            32'(byte_q.size() - b0), 32'd20);
        chk(mem[BASE_W] === 32'h0, "R9", "in-progress status", mem[BASE_W], 32'h0);
        chk(mem[BASE_W + 4] === 32'h8000_0000, "R9", "next descriptor untouched",
            mem[BASE_W + 4], 32'h8000_0000);
        tx_run = 1'b1;
        r0 = rd_cnt;
        poll(32'd1);
        wait_quiet();
        chk(last_rd === BASE, "R9", "restart at ring base", last_rd, BASE);
        chk(rd_cnt - r0 == 1, "R3", "suspend on unowned base", 32'(rd_cnt - r0), 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule